// File: doc/BRIEF.md
# PHY Loopback Path Selector

This block sits between the MAC-facing and line-facing byte streams of a PHY datapath. It decides where the receive stream that goes up to the MAC comes from, and where the transmit stream that goes out to the line comes from. In normal operation the MAC transmit stream goes to the line and the line receive stream goes to the MAC. When a loopback is configured, one stream is turned back at a chosen point. That point is either one of four whole-datapath loop modes or a PCS-internal loop point whose meaning depends on the link speed.

Configuration is loaded by a one-cycle write strobe that carries all fields at once. The mode field is one-hot. The PCS loop-point field must already be clear when a nonzero mode is written. A write that breaks this order is refused and flagged. Two pass-through bits decide whether the original stream is also kept alive during digital and reverse loops. Each bit has an effect only in its own mode. Every stream output is registered, so an output follows its selected input with one cycle of latency.

Top module: `lbk_path_sel`

## Requirements
- R1: During and right after a synchronous active-low reset, both stream outputs have valid 0 and data 0, `cfg_err` is 0, and the configuration is cleared (mode 0000, PCS point 00, both pass bits 0).
- R2: With mode 0000 and a PCS point that selects no loop, `mac_rx` equals the `line_rx` {valid,data} of the previous cycle, and `line_tx` equals the `mac_tx` of the previous cycle.
- R3: Digital loop (mode 0001): `mac_rx` carries the previous cycle's `mac_tx`. `line_tx` carries `mac_tx` when the tx pass bit is 1 and is suppressed when it is 0.
- R4: Analog loop (mode 0010): `mac_rx` carries the previous cycle's after-line-encoder tap, and `line_tx` carries `mac_tx`.
- R5: External loop (mode 0100): both outputs follow the normal paths of R2, because the turn-around is outside the device.
- R6: Reverse loop (mode 1000): `line_tx` carries the previous cycle's `line_rx`. `mac_rx` carries `line_rx` when the rx pass bit is 1 and is suppressed when it is 0.
- R7: The tx pass bit has no effect in any mode other than 0001, and the rx pass bit has no effect in any mode other than 1000.
- R8: At 100 Mb/s (`speed_gig`=0) with mode 0000, the PCS point routes a stage tap to `mac_rx`: 01 the before-scrambler tap, 10 the after-scrambler tap, 11 the after-line-encoder tap. `line_tx` carries `mac_tx`.
- R9: At 1000 Mb/s (`speed_gig`=1) with mode 0000, a PCS point with bit 0 set routes the gigabit-processing tap to `mac_rx`, and PCS point 10 selects no loop.
- R10: A write whose mode is nonzero, while the stored PCS point or the written PCS point is nonzero, stores mode 0000 and stores the written PCS point. `cfg_err` then reads 1 from the cycle after that write until the next write that does not break this rule.
- R11: A stored mode that is nonzero and not one-hot makes `cfg_err` 1 and is routed as mode 0000.
- R12: A suppressed output drives valid 0 and data 0. It does not hold its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| speed_gig | input | 1 | 1 = 1000 Mb/s, 0 = 100 Mb/s |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 4 | Loop mode, one-hot (0001 digital, 0010 analog, 0100 external, 1000 reverse) |
| cfg_pcs | input | 2 | PCS loop point |
| cfg_tx_pass | input | 1 | Keep line transmit alive in digital loop |
| cfg_rx_pass | input | 1 | Keep MAC receive alive in reverse loop |
| mac_tx_v | input | 1 | MAC transmit valid |
| mac_tx_d | input | 8 | MAC transmit byte |
| line_rx_v | input | 1 | Line receive valid |
| line_rx_d | input | 8 | Line receive byte |
| tap_pre_scr_v | input | 1 | Before-scrambler tap valid |
| tap_pre_scr_d | input | 8 | Before-scrambler tap byte |
| tap_post_scr_v | input | 1 | After-scrambler tap valid |
| tap_post_scr_d | input | 8 | After-scrambler tap byte |
| tap_post_enc_v | input | 1 | After-line-encoder tap valid |
| tap_post_enc_d | input | 8 | After-line-encoder tap byte |
| tap_gig_v | input | 1 | Before-gigabit-processing tap valid |
| tap_gig_d | input | 8 | Before-gigabit-processing tap byte |
| mac_rx_v | output | 1 | MAC receive valid |
| mac_rx_d | output | 8 | MAC receive byte |
| line_tx_v | output | 1 | Line transmit valid |
| line_tx_d | output | 8 | Line transmit byte |
| cfg_err | output | 1 | Illegal or refused configuration |

## Verification
The assertions assume that `speed_gig` and the configuration change only through the write strobe. They also assume that the stage taps arrive already aligned to the cycle in which they are used. The stream checks compare each output with the selected input of the previous cycle, so those inputs must be free to take any value. The stimulus follows these assumptions. It holds the speed steady around each check and draws bytes and valid bits from a seeded `$urandom`. Most configuration writes are legal, and a minority carry refused or non-one-hot values, so R10 and R11 are exercised as well.

// File: rtl/lbk_pkg.sv
// Package: shared route codes and helpers for the loopback path selector.
// Assumes: the mode field is one-hot with the bit order fixed below.
package lbk_pkg;

    // Source that can feed one output stream; SRC_OFF is the suppressed slot.
    typedef enum logic [2:0] {
        SRC_OFF      = 3'd0,
        SRC_MAC_TX   = 3'd1,
        SRC_LINE_RX  = 3'd2,
        SRC_PRE_SCR  = 3'd3,
        SRC_POST_SCR = 3'd4,
        SRC_POST_ENC = 3'd5,
        SRC_GIG      = 3'd6
    } src_e;

    localparam int NUM_SRC = 7;
    localparam int MODE_W  = 4;
    localparam int PCS_W   = 2;

    localparam logic [MODE_W-1:0] MODE_NONE = 4'b0000;
    localparam logic [MODE_W-1:0] MODE_DIG  = 4'b0001;
    localparam logic [MODE_W-1:0] MODE_ANA  = 4'b0010;
    localparam logic [MODE_W-1:0] MODE_EXT  = 4'b0100;
    localparam logic [MODE_W-1:0] MODE_REV  = 4'b1000;

    // True when a nonzero mode has more than one bit set.
    function automatic logic mode_is_bad(input logic [MODE_W-1:0] m);
        return (m != '0) && ((m & (m - 1'b1)) != '0);
    endfunction

endpackage

// File: rtl/lbk_cfg_regs.sv
// Module: configuration holding registers with write-order enforcement.
// Assumes: all fields arrive together on a single-cycle write strobe.
// A nonzero mode written while the PCS point (stored or written) is nonzero
// is refused: mode is stored as zero and the order error is latched.
module lbk_cfg_regs
    import lbk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [PCS_W-1:0]  pcs_i,
    input  logic              txp_i,
    input  logic              rxp_i,
    output logic [MODE_W-1:0] mode_q,
    output logic [PCS_W-1:0]  pcs_q,
    output logic              txp_q,
    output logic              rxp_q,
    output logic              bad_mode_o,
    output logic              err_o
);

    logic order_viol;
    logic order_err_q;

    // Detect a mode write that arrives while a PCS loop point is still set.
    always_comb begin
        order_viol = (mode_i != '0) && ((pcs_q != '0) || (pcs_i != '0));
    end

    // Load configuration on write, refusing the mode on an order violation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q      <= '0;
            pcs_q       <= '0;
            txp_q       <= 1'b0;
            rxp_q       <= 1'b0;
            order_err_q <= 1'b0;
        end else if (we_i) begin
            mode_q      <= order_viol ? MODE_NONE : mode_i;
            pcs_q       <= pcs_i;
            txp_q       <= txp_i;
            rxp_q       <= rxp_i;
            order_err_q <= order_viol;
        end
    end

    // Flag a stored mode that is neither zero nor one-hot.
    always_comb begin
        bad_mode_o = mode_is_bad(mode_q);
        err_o      = order_err_q | bad_mode_o;
    end

    AST_MODE_NEEDS_CLEAR_PCS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != '0) |-> (pcs_q == '0)); // R10

    AST_ORDER_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && (mode_i != '0) && ((pcs_q != '0) || (pcs_i != '0)))
        |=> ((mode_q == '0) && err_o)); // R10

endmodule

// File: rtl/lbk_route_dec.sv
// Module: decodes the stored configuration and speed into two source selects.
// Assumes: a bad mode has already been flagged; it is routed as no loop.
module lbk_route_dec
    import lbk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [PCS_W-1:0]  pcs_i,
    input  logic              txp_i,
    input  logic              rxp_i,
    input  logic              gig_i,
    input  logic              bad_mode_i,
    output src_e              rx_sel_o,
    output src_e              tx_sel_o
);

    logic [MODE_W-1:0] eff_mode;

    // Collapse an illegal mode to no loop.
    always_comb begin
        eff_mode = bad_mode_i ? MODE_NONE : mode_i;
    end

    // Choose the source of each output from mode, PCS point and speed.
    always_comb begin
        rx_sel_o = SRC_LINE_RX;
        tx_sel_o = SRC_MAC_TX;
        unique case (eff_mode)
            MODE_DIG: begin
                rx_sel_o = SRC_MAC_TX;
                tx_sel_o = txp_i ? SRC_MAC_TX : SRC_OFF;
            end
            MODE_ANA: begin
                rx_sel_o = SRC_POST_ENC;
            end
            MODE_EXT: begin
                rx_sel_o = SRC_LINE_RX;
            end
            MODE_REV: begin
                tx_sel_o = SRC_LINE_RX;
                rx_sel_o = rxp_i ? SRC_LINE_RX : SRC_OFF;
            end
            default: begin
                if (gig_i) begin
                    if (pcs_i[0]) rx_sel_o = SRC_GIG;
                end else begin
                    unique case (pcs_i)
                        2'b01:   rx_sel_o = SRC_PRE_SCR;
                        2'b10:   rx_sel_o = SRC_POST_SCR;
                        2'b11:   rx_sel_o = SRC_POST_ENC;
                        default: rx_sel_o = SRC_LINE_RX;
                    endcase
                end
            end
        endcase
    end

    AST_TX_PASS_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_sel_o == SRC_OFF) |-> (eff_mode == MODE_DIG)); // R7

    AST_RX_PASS_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_sel_o == SRC_OFF) |-> (eff_mode == MODE_REV)); // R7

endmodule

// File: rtl/lbk_stream_mux.sv
// Module: registered selector of one {valid,data} stream out of NSRC sources.
// Assumes: slot 0 of the source array is the all-zero suppressed source.
module lbk_stream_mux
    import lbk_pkg::*;
#(
    parameter int DW   = 8,
    parameter int NSRC = NUM_SRC
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW:0]   src_i [NSRC],
    input  src_e          sel_i,
    output logic          out_v,
    output logic [DW-1:0] out_d
);

    logic [DW:0] pick;

    // Pick the selected source, defaulting to the suppressed value.
    always_comb begin
        pick = '0;
        for (int k = 0; k < NSRC; k++) begin
            if (int'(sel_i) == k) pick = src_i[k];
        end
    end

    // Register the chosen stream; reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_v <= 1'b0;
            out_d <= '0;
        end else begin
            out_v <= pick[DW];
            out_d <= pick[DW-1:0];
        end
    end

    AST_SUPPRESS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == SRC_OFF) |=> (!out_v && (out_d == '0))); // R12

endmodule

// File: rtl/lbk_path_sel.sv
// Module: top of the loopback path selector. Holds configuration, decodes
// the loop point and drives the MAC receive and line transmit streams.
// Assumes: stage taps are aligned to the cycle they are presented in.
module lbk_path_sel
    import lbk_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          speed_gig,
    input  logic          cfg_we,
    input  logic [3:0]    cfg_mode,
    input  logic [1:0]    cfg_pcs,
    input  logic          cfg_tx_pass,
    input  logic          cfg_rx_pass,
    input  logic          mac_tx_v,
    input  logic [DW-1:0] mac_tx_d,
    input  logic          line_rx_v,
    input  logic [DW-1:0] line_rx_d,
    input  logic          tap_pre_scr_v,
    input  logic [DW-1:0] tap_pre_scr_d,
    input  logic          tap_post_scr_v,
    input  logic [DW-1:0] tap_post_scr_d,
    input  logic          tap_post_enc_v,
    input  logic [DW-1:0] tap_post_enc_d,
    input  logic          tap_gig_v,
    input  logic [DW-1:0] tap_gig_d,
    output logic          mac_rx_v,
    output logic [DW-1:0] mac_rx_d,
    output logic          line_tx_v,
    output logic [DW-1:0] line_tx_d,
    output logic          cfg_err
);

    localparam int SW = DW + 1;

    logic [MODE_W-1:0] mode_q;
    logic [PCS_W-1:0]  pcs_q;
    logic              txp_q;
    logic              rxp_q;
    logic              bad_mode;
    src_e              rx_sel;
    src_e              tx_sel;
    logic [SW-1:0]     srcs [NUM_SRC];

    lbk_cfg_regs u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (cfg_we),
        .mode_i     (cfg_mode),
        .pcs_i      (cfg_pcs),
        .txp_i      (cfg_tx_pass),
        .rxp_i      (cfg_rx_pass),
        .mode_q     (mode_q),
        .pcs_q      (pcs_q),
        .txp_q      (txp_q),
        .rxp_q      (rxp_q),
        .bad_mode_o (bad_mode),
        .err_o      (cfg_err)
    );

    lbk_route_dec u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode_q),
        .pcs_i      (pcs_q),
        .txp_i      (txp_q),
        .rxp_i      (rxp_q),
        .gig_i      (speed_gig),
        .bad_mode_i (bad_mode),
        .rx_sel_o   (rx_sel),
        .tx_sel_o   (tx_sel)
    );

    // Gather every candidate stream into one source table, indexed by src_e.
    always_comb begin
        srcs[SRC_OFF]      = '0;
        srcs[SRC_MAC_TX]   = {mac_tx_v, mac_tx_d};
        srcs[SRC_LINE_RX]  = {line_rx_v, line_rx_d};
        srcs[SRC_PRE_SCR]  = {tap_pre_scr_v, tap_pre_scr_d};
        srcs[SRC_POST_SCR] = {tap_post_scr_v, tap_post_scr_d};
        srcs[SRC_POST_ENC] = {tap_post_enc_v, tap_post_enc_d};
        srcs[SRC_GIG]      = {tap_gig_v, tap_gig_d};
    end

    // One registered selector per output stream.
    for (genvar g = 0; g < 2; g++) begin : g_out
        logic          o_v;
        logic [DW-1:0] o_d;
        lbk_stream_mux #(.DW(DW), .NSRC(NUM_SRC)) u_mux (
            .clk   (clk),
            .rst_n (rst_n),
            .src_i (srcs),
            .sel_i ((g == 0) ? rx_sel : tx_sel),
            .out_v (o_v),
            .out_d (o_d)
        );
    end

    assign mac_rx_v  = g_out[0].o_v;
    assign mac_rx_d  = g_out[0].o_d;
    assign line_tx_v = g_out[1].o_v;
    assign line_tx_d = g_out[1].o_d;

    AST_NORMAL_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == MODE_NONE) && (pcs_q == '0))
        |=> ((mac_rx_d == $past(line_rx_d)) && (line_tx_d == $past(mac_tx_d)))); // R2

    AST_DIG_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_DIG)
        |=> ((mac_rx_v == $past(mac_tx_v)) && (mac_rx_d == $past(mac_tx_d)))); // R3

    AST_REV_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_REV)
        |=> ((line_tx_v == $past(line_rx_v)) && (line_tx_d == $past(line_rx_d)))); // R6

    AST_BAD_MODE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(mode_q) > 1) |-> cfg_err); // R11

endmodule

// File: tb/lbk_path_sel_tb.sv
module lbk_path_sel_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       speed_gig = 1'b0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_mode = '0;
    logic [1:0] cfg_pcs = '0;
    logic       cfg_tx_pass = 1'b0;
    logic       cfg_rx_pass = 1'b0;
    logic [8:0] s_mtx = '0, s_lrx = '0, s_pre = '0, s_pst = '0, s_enc = '0, s_gig = '0;
    logic       mac_rx_v, line_tx_v, cfg_err;
    logic [7:0] mac_rx_d, line_tx_d;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model configuration
    logic [3:0] m_mode = '0;
    logic [1:0] m_pcs = '0;
    bit m_txp = 0, m_rxp = 0, m_seq = 0;

    always #10 clk = ~clk;

    lbk_path_sel u_dut (
        .clk(clk), .rst_n(rst_n), .speed_gig(speed_gig), .cfg_we(cfg_we),
        .cfg_mode(cfg_mode), .cfg_pcs(cfg_pcs), .cfg_tx_pass(cfg_tx_pass),
        .cfg_rx_pass(cfg_rx_pass),
        .mac_tx_v(s_mtx[8]), .mac_tx_d(s_mtx[7:0]),
        .line_rx_v(s_lrx[8]), .line_rx_d(s_lrx[7:0]),
        .tap_pre_scr_v(s_pre[8]), .tap_pre_scr_d(s_pre[7:0]),
        .tap_post_scr_v(s_pst[8]), .tap_post_scr_d(s_pst[7:0]),
        .tap_post_enc_v(s_enc[8]), .tap_post_enc_d(s_enc[7:0]),
        .tap_gig_v(s_gig[8]), .tap_gig_d(s_gig[7:0]),
        .mac_rx_v(mac_rx_v), .mac_rx_d(mac_rx_d),
        .line_tx_v(line_tx_v), .line_tx_d(line_tx_d), .cfg_err(cfg_err)
    );

    function automatic bit bad_mode(input logic [3:0] m);
        return (m != 0) && ($countones(m) != 1);
    endfunction

    function automatic logic [3:0] eff_mode();
        return bad_mode(m_mode) ? 4'b0000 : m_mode;
    endfunction

    // expected MAC receive stream from the requirements
    function automatic logic [8:0] exp_rx();
        case (eff_mode())
            4'b0001: return s_mtx;                     // R3
            4'b0010: return s_enc;                     // R4
            4'b0100: return s_lrx;                     // R5
            4'b1000: return m_rxp ? s_lrx : 9'd0;      // R6
            default: begin
                if (speed_gig) return m_pcs[0] ? s_gig : s_lrx;   // R9
                case (m_pcs)                                      // R8
                    2'b01:   return s_pre;
                    2'b10:   return s_pst;
                    2'b11:   return s_enc;
                    default: return s_lrx;
                endcase
            end
        endcase
    endfunction

    // expected line transmit stream from the requirements
    function automatic logic [8:0] exp_tx();
        case (eff_mode())
            4'b0001: return m_txp ? s_mtx : 9'd0;
            4'b1000: return s_lrx;
            default: return s_mtx;
        endcase
    endfunction

    function automatic string auto_tag();
        if (bad_mode(m_mode)) return "R11";
        case (m_mode)
            4'b0001: return "R3";
            4'b0010: return "R4";
            4'b0100: return "R5";
            4'b1000: return "R6";
            default: return (m_pcs == 0) ? "R2" : (speed_gig ? "R9" : "R8");
        endcase
    endfunction

    task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic rand_data();
        s_mtx = 9'($urandom); s_lrx = 9'($urandom); s_pre = 9'($urandom);
        s_pst = 9'($urandom); s_enc = 9'($urandom); s_gig = 9'($urandom);
    endtask

    // one clock: predict, advance model at the edge, compare after the edge
    task automatic cycle(input string tag);
        logic [8:0] erx, etx;
        bit viol;
        string t;
        erx = exp_rx();
        etx = exp_tx();
        t = (tag == "") ? auto_tag() : tag;
        @(posedge clk);
        if (cfg_we) begin
            viol = (cfg_mode != 0) && ((m_pcs != 0) || (cfg_pcs != 0));
            m_mode = viol ? 4'b0000 : cfg_mode;
            m_pcs = cfg_pcs;
            m_txp = cfg_tx_pass;
            m_rxp = cfg_rx_pass;
            m_seq = viol;
        end
        @(negedge clk);
        chk(t, {mac_rx_v, mac_rx_d}, erx);
        chk(t, {line_tx_v, line_tx_d}, etx);
        chk((tag == "") ? "R10" : tag, {8'd0, cfg_err}, {8'd0, m_seq | bad_mode(m_mode)});
        rand_data();
    endtask

    task automatic wr(input logic [3:0] m, input logic [1:0] p, input bit tx, input bit rx,
                      input string tag);
        cfg_we = 1'b1; cfg_mode = m; cfg_pcs = p; cfg_tx_pass = tx; cfg_rx_pass = rx;
        cycle(tag);
        cfg_we = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd2468));
        rand_data();
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", {mac_rx_v, mac_rx_d}, 9'd0);
        chk("R1", {line_tx_v, line_tx_d}, 9'd0);
        chk("R1", {8'd0, cfg_err}, 9'd0);
        rst_n = 1'b1;
        // R2: normal path
        repeat (4) cycle("R2");
        // R3 and R12: digital loop, tx suppressed then passed
        wr(4'b0001, 2'b00, 1'b0, 1'b1, "R3");
        repeat (3) cycle("R12");
        wr(4'b0001, 2'b00, 1'b1, 1'b0, "R7");
        repeat (3) cycle("R3");
        // R4, R5
        wr(4'b0010, 2'b00, 1'b0, 1'b0, "R4");
        repeat (3) cycle("R4");
        wr(4'b0100, 2'b00, 1'b1, 1'b1, "R5");
        repeat (3) cycle("R7");
        // R6: reverse loop, rx suppressed then passed; tx pass ignored
        wr(4'b1000, 2'b00, 1'b0, 1'b0, "R6");
        repeat (3) cycle("R12");
        wr(4'b1000, 2'b00, 1'b1, 1'b1, "R7");
        repeat (3) cycle("R6");
        // R8: each PCS point at 100 Mb/s
        wr(4'b0000, 2'b01, 1'b0, 1'b0, "R8");
        repeat (2) cycle("R8");
        wr(4'b0000, 2'b10, 1'b0, 1'b0, "R8");
        repeat (2) cycle("R8");
        wr(4'b0000, 2'b11, 1'b0, 1'b0, "R8");
        repeat (2) cycle("R8");
        // R10: mode written while PCS point still set
        wr(4'b0001, 2'b00, 1'b0, 1'b0, "R10");
        repeat (2) cycle("R10");
        // R9: gigabit points
        speed_gig = 1'b1;
        wr(4'b0000, 2'b01, 1'b0, 1'b0, "R9");
        repeat (2) cycle("R9");
        wr(4'b0000, 2'b10, 1'b0, 1'b0, "R9");
        repeat (2) cycle("R9");
        wr(4'b0000, 2'b00, 1'b0, 1'b0, "R9");
        // R11: non-one-hot mode
        wr(4'b0101, 2'b00, 1'b1, 1'b1, "R11");
        repeat (3) cycle("R11");
        speed_gig = 1'b0;
        // random configuration and data
        for (int i = 0; i < 3000; i++) begin
            if (($urandom % 8) == 0) begin
                if (($urandom % 10) < 7) begin
                    if ($urandom % 2)
                        wr(4'b0001 << ($urandom % 4), 2'b00, 1'($urandom), 1'($urandom), "");
                    else
                        wr(4'b0000, 2'($urandom), 1'($urandom), 1'($urandom), "");
                end else begin
                    wr(4'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), "");
                end
            end else begin
                if (($urandom % 64) == 0) speed_gig = ~speed_gig;
                cycle("");
            end
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog act=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule